// File: doc/BRIEF.md
# Priority Reference Selector with Holdover

This block picks the active timing reference for a line card from five clock inputs. There is a Master and a Slave source, each available single-ended or differential, and there is a Stand-by source. Every input carries a valid flag and a 4-bit priority. The selector chooses the best valid input and reports its channel code. It also reports the three best valid candidates. Configuration can force the choice onto one channel. A revertive bit decides whether a repaired better source takes the selection back. An external pin exchanges the Master and Slave priorities and triggers an immediate re-selection.

Each clock belongs to a group: Master, Slave or Stand-by. The group's sync pulse is routed to `sync_out` together with the selected clock. The block also tracks the operating state of the downstream loop. It starts in free-run, moves to locked once a reference is selected and lock is reported, and drops into holdover at once when a locked loop loses its last reference. The loop itself lives outside the block.

Top module: `refsel_top`

## Requirements
- R1: Channel codes are 0011 (Master single-ended, `src_valid[0]`), 0100 (Slave single-ended, bit 1), 0101 (Master differential, bit 2), 0110 (Slave differential, bit 3) and 1001 (Stand-by, bit 4). The priority of channel i is `src_prio[4i+3:4i]`. Among valid inputs with a nonzero priority, the lowest priority value wins. On equal values the lower channel code wins. `sel_code` and the rank outputs update on the clock edge after their inputs.
- R2: `rank1_code`, `rank2_code` and `rank3_code` give the best, second and third eligible channel codes from the ordering of R1. Any unfilled place shows 0000. The force input never changes them.
- R3: With `revertive`=1 and no force, the selection always follows the best eligible input.
- R4: With `revertive`=0, a selected input stays selected while it is valid and has a nonzero priority, even if a better input becomes valid. When it fails, the best eligible input takes over.
- R5: When `force_code` equals one of the five channel codes, that channel is selected if it is valid, whatever its priority. If it is invalid, the selection is 0000. Any other value of `force_code` means no force.
- R6: While `swap_pin` is high, each Master channel uses the priority of its Slave twin and each Slave channel uses the priority of its Master twin. Any change of `swap_pin` forces a fresh priority selection, even in non-revertive mode.
- R7: `op_mode` encodes 00 free-run, 01 locked and 10 holdover. In locked mode, a selection of 0000 moves the mode to holdover on the next edge.
- R8: After reset, `sel_code`, the three ranks and `sync_out` are 0000/0 and `op_mode` is free-run. From free-run or holdover, the mode becomes locked on the edge after a nonzero selection is seen together with `lock_ok`=1.
- R9: `sync_out` follows the sync of the selected group: `sync_in[0]` for Master, `sync_in[1]` for Slave, `sync_in[2]` for Stand-by. It is 0 when nothing is selected. Sync activity never affects the selection.
- R10: A priority of 0 removes an input from automatic selection and from the ranks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 5 | Per-channel valid flag |
| src_prio | input | 20 | Four-bit priority per channel, channel 0 in the low bits |
| force_code | input | 4 | Forced channel code; non-matching value means no force |
| revertive | input | 1 | 1 = revertive, 0 = non-revertive |
| swap_pin | input | 1 | External Master/Slave fast-switch pin |
| lock_ok | input | 1 | Loop reports lock achieved |
| sync_in | input | 3 | Sync pulses of the Master, Slave and Stand-by groups |
| sel_code | output | 4 | Selected channel code, 0000 for none |
| op_mode | output | 2 | Operating state |
| rank1_code | output | 4 | Best eligible channel code |
| rank2_code | output | 4 | Second-best eligible channel code |
| rank3_code | output | 4 | Third-best eligible channel code |
| sync_out | output | 1 | Sync of the selected group |

## Verification
Some rules are checked by the assertions on every cycle:
- A nonzero selection always names an input that was valid.
- A valid forced channel is taken on the next edge.
- Revertive mode tracks the best rank.
- The ranks are distinct and filled from the top.
- Locked mode falls to holdover when the selection empties.
- Free-run never reaches locked without lock.

Other behaviours need the bench's ordered scenarios, because they depend on history:
- the non-revertive hold on a repaired source;
- the tie rule;
- the swap re-selection that overrides the hold;
- the zero-priority exclusion;
- the routing of each group's sync.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NUM_CH  = 5;
  localparam int NUM_GRP = 3;
  localparam int CODE_W  = 4;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_LOCKED = 2'd1,
    MODE_HOLD   = 2'd2
  } op_mode_t;

  // channel index -> externally visible code
  function automatic logic [CODE_W-1:0] ch_code(input int idx);
    case (idx)
      0:       return 4'b0011;
      1:       return 4'b0100;
      2:       return 4'b0101;
      3:       return 4'b0110;
      4:       return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  // channel index -> sync group (0 Master, 1 Slave, 2 Stand-by)
  function automatic int ch_group(input int idx);
    case (idx)
      0, 2:    return 0;
      1, 3:    return 1;
      default: return 2;
    endcase
  endfunction

  // Master/Slave twin used by the swap pin
  function automatic int ch_partner(input int idx);
    case (idx)
      0:       return 1;
      1:       return 0;
      2:       return 3;
      3:       return 2;
      default: return idx;
    endcase
  endfunction
endpackage

// File: rtl/refsel_rank.sv
module refsel_rank #(
  parameter int NUM_CH   = 5,
  parameter int PRIO_W   = 4,
  parameter int NUM_PICK = 3,
  parameter int IDX_W    = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]         valid,
  input  logic [NUM_CH*PRIO_W-1:0]  prio,
  input  logic                      swap,
  output logic [NUM_CH-1:0]         elig,
  output logic [NUM_PICK-1:0]       pick_vld,
  output logic [NUM_PICK*IDX_W-1:0] pick_idx
);
  logic [PRIO_W-1:0] eff [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int PARTNER = refsel_pkg::ch_partner(i);
    assign eff[i]  = swap ? prio[PARTNER*PRIO_W +: PRIO_W] : prio[i*PRIO_W +: PRIO_W];
    assign elig[i] = valid[i] && (eff[i] != '0);
  end

  logic [NUM_CH-1:0] taken;
  logic              found;
  logic [IDX_W-1:0]  bidx;
  logic [PRIO_W-1:0] bpri;

  // successive minimum search; strict compare keeps the lower index on ties
  always_comb begin
    taken    = '0;
    pick_vld = '0;
    pick_idx = '0;
    found    = 1'b0;
    bidx     = '0;
    bpri     = '1;
    for (int r = 0; r < NUM_PICK; r++) begin
      found = 1'b0;
      bidx  = '0;
      bpri  = '1;
      for (int i = 0; i < NUM_CH; i++) begin
        if (elig[i] && !taken[i] && (!found || eff[i] < bpri)) begin
          found = 1'b1;
          bidx  = IDX_W'(i);
          bpri  = eff[i];
        end
      end
      pick_vld[r] = found;
      pick_idx[r*IDX_W +: IDX_W] = bidx;
      if (found) taken[bidx] = 1'b1;
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int NUM_CH = 5,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH-1:0]             valid,
  input  logic [NUM_CH-1:0]             elig,
  input  logic [refsel_pkg::CODE_W-1:0] force_code,
  input  logic                          revertive,
  input  logic                          swap_pin,
  input  logic                          best_vld,
  input  logic [IDX_W-1:0]              best_idx,
  output logic                          sel_vld,
  output logic [IDX_W-1:0]              sel_idx
);
  logic             swap_q;
  logic             force_hit;
  logic [IDX_W-1:0] force_idx;
  logic             keep_cur;
  logic             nxt_vld;
  logic [IDX_W-1:0] nxt_idx;

  always_comb begin
    force_hit = 1'b0;
    force_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (refsel_pkg::ch_code(i) == force_code) begin
        force_hit = 1'b1;
        force_idx = IDX_W'(i);
      end
    end
  end

  assign keep_cur = sel_vld && elig[sel_idx];

  always_comb begin
    nxt_vld = best_vld;
    nxt_idx = best_idx;
    if (force_hit) begin
      nxt_vld = valid[force_idx];
      nxt_idx = force_idx;
    end else if (!revertive && (swap_pin == swap_q) && keep_cur) begin
      nxt_vld = 1'b1;
      nxt_idx = sel_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld <= 1'b0;
      sel_idx <= '0;
      swap_q  <= 1'b0;
    end else begin
      sel_vld <= nxt_vld;
      sel_idx <= nxt_vld ? nxt_idx : '0;
      swap_q  <= swap_pin;
    end
  end
endmodule

// File: rtl/refsel_mode.sv
module refsel_mode (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_vld,
  input  logic                 lock_ok,
  output refsel_pkg::op_mode_t mode
);
  import refsel_pkg::*;
  op_mode_t nxt;

  always_comb begin
    nxt = mode;
    case (mode)
      MODE_LOCKED: if (!sel_vld)           nxt = MODE_HOLD;
      MODE_FREE,
      MODE_HOLD:   if (sel_vld && lock_ok) nxt = MODE_LOCKED;
      default:                             nxt = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_FREE;
    else     mode <= nxt;
  end
endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int PRIO_W   = 4,
  parameter int NUM_PICK = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [refsel_pkg::NUM_CH-1:0]          src_valid,
  input  logic [refsel_pkg::NUM_CH*PRIO_W-1:0]   src_prio,
  input  logic [refsel_pkg::CODE_W-1:0]          force_code,
  input  logic                                   revertive,
  input  logic                                   swap_pin,
  input  logic                                   lock_ok,
  input  logic [refsel_pkg::NUM_GRP-1:0]         sync_in,
  output logic [refsel_pkg::CODE_W-1:0]          sel_code,
  output logic [1:0]                             op_mode,
  output logic [refsel_pkg::CODE_W-1:0]          rank1_code,
  output logic [refsel_pkg::CODE_W-1:0]          rank2_code,
  output logic [refsel_pkg::CODE_W-1:0]          rank3_code,
  output logic                                   sync_out
);
  import refsel_pkg::*;
  localparam int IDX_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]         elig;
  logic [NUM_PICK-1:0]       pick_vld;
  logic [NUM_PICK*IDX_W-1:0] pick_idx;
  logic                      sel_vld;
  logic [IDX_W-1:0]          sel_idx;
  op_mode_t                  mode;
  logic [CODE_W-1:0]         rank_q [NUM_PICK];
  logic                      sync_q;

  refsel_rank #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .NUM_PICK(NUM_PICK), .IDX_W(IDX_W)) u_rank (
    .valid(src_valid), .prio(src_prio), .swap(swap_pin),
    .elig(elig), .pick_vld(pick_vld), .pick_idx(pick_idx));

  refsel_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .valid(src_valid), .elig(elig),
    .force_code(force_code), .revertive(revertive), .swap_pin(swap_pin),
    .best_vld(pick_vld[0]), .best_idx(pick_idx[IDX_W-1:0]),
    .sel_vld(sel_vld), .sel_idx(sel_idx));

  refsel_mode u_mode (
    .clk(clk), .rst(rst), .sel_vld(sel_vld), .lock_ok(lock_ok), .mode(mode));

  for (genvar r = 0; r < NUM_PICK; r++) begin : g_rank
    always_ff @(posedge clk) begin
      if (rst)              rank_q[r] <= '0;
      else if (pick_vld[r]) rank_q[r] <= ch_code(int'(pick_idx[r*IDX_W +: IDX_W]));
      else                  rank_q[r] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sync_q <= 1'b0;
    else if (sel_vld) sync_q <= sync_in[ch_group(int'(sel_idx))];
    else              sync_q <= 1'b0;
  end

  assign sel_code   = sel_vld ? ch_code(int'(sel_idx)) : '0;
  assign op_mode    = mode;
  assign rank1_code = rank_q[0];
  assign rank2_code = rank_q[1];
  assign rank3_code = rank_q[2];
  assign sync_out   = sync_q;
endmodule

// File: rtl/refsel_check.sv
module refsel_check (
  input logic                          clk,
  input logic                          rst,
  input logic [refsel_pkg::NUM_CH-1:0] src_valid,
  input logic [refsel_pkg::CODE_W-1:0] force_code,
  input logic                          revertive,
  input logic                          lock_ok,
  input logic [refsel_pkg::CODE_W-1:0] sel_code,
  input logic [1:0]                    op_mode,
  input logic [refsel_pkg::CODE_W-1:0] rank1_code,
  input logic [refsel_pkg::CODE_W-1:0] rank2_code,
  input logic [refsel_pkg::CODE_W-1:0] rank3_code
);
  import refsel_pkg::*;
  logic [NUM_CH-1:0] prev_valid;
  logic              force_hit;
  logic              force_ok;
  logic              sel_was_valid;

  always_ff @(posedge clk) prev_valid <= src_valid;

  always_comb begin
    force_hit     = 1'b0;
    force_ok      = 1'b0;
    sel_was_valid = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_code(i) == force_code) begin
        force_hit = 1'b1;
        force_ok  = src_valid[i];
      end
      if (ch_code(i) == sel_code) sel_was_valid = prev_valid[i];
    end
  end

  assert_sel_valid_R1: assert property (@(posedge clk) disable iff (rst)
    (sel_code != 4'b0000) |-> sel_was_valid);

  assert_rank_fill_R2: assert property (@(posedge clk) disable iff (rst)
    ((rank2_code != 4'b0000) |-> (rank1_code != 4'b0000 && rank1_code != rank2_code)) and
    ((rank3_code != 4'b0000) |-> (rank2_code != 4'b0000 && rank3_code != rank2_code && rank3_code != rank1_code)));

  assert_revert_best_R3: assert property (@(posedge clk) disable iff (rst)
    (revertive && !force_hit) |=> (sel_code == rank1_code));

  assert_force_take_R5: assert property (@(posedge clk) disable iff (rst)
    force_ok |=> (sel_code == $past(force_code)));

  assert_holdover_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (op_mode == MODE_LOCKED && sel_code == 4'b0000) |=> (op_mode == MODE_HOLD));

  assert_no_lock_no_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (op_mode == MODE_FREE && !lock_ok) |=> (op_mode != MODE_LOCKED));
endmodule

bind refsel_top refsel_check i_refsel_check (
  .clk(clk), .rst(rst), .src_valid(src_valid), .force_code(force_code),
  .revertive(revertive), .lock_ok(lock_ok), .sel_code(sel_code), .op_mode(op_mode),
  .rank1_code(rank1_code), .rank2_code(rank2_code), .rank3_code(rank3_code));

// File: tb/test_refsel_top.sv
module test_refsel_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src_valid = '0;
  logic [19:0] src_prio = '0;
  logic [3:0]  force_code = '0;
  logic        revertive = 1'b0;
  logic        swap_pin = 1'b0;
  logic        lock_ok = 1'b0;
  logic [2:0]  sync_in = '0;
  logic [3:0]  sel_code, rank1_code, rank2_code, rank3_code;
  logic [1:0]  op_mode;
  logic        sync_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refsel_top i_refsel_top (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_prio(src_prio),
    .force_code(force_code), .revertive(revertive), .swap_pin(swap_pin),
    .lock_ok(lock_ok), .sync_in(sync_in), .sel_code(sel_code), .op_mode(op_mode),
    .rank1_code(rank1_code), .rank2_code(rank2_code), .rank3_code(rank3_code),
    .sync_out(sync_out));

  // {valid, prio(ch4..ch0), force, rev, swap, lock, sel, r1, r2, r3, mode}
  localparam int NV = 17;
  localparam logic [49:0] VEC [NV] = '{
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b0, 4'h3, 4'h3, 4'h4, 4'h9, 2'd0}, // R1 defaults, free-run
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h9, 2'd1}, // R8 lock
    {5'b11110, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 4'h4, 4'h9, 4'h0, 2'd1}, // R4 failover
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 4'h3, 4'h4, 4'h9, 2'd1}, // R4 hold repaired
    {5'b11111, 20'h40032, 4'h0, 1'b1, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h9, 2'd1}, // R3 revert
    {5'b00000, 20'h40032, 4'h0, 1'b1, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd2}, // R7 holdover
    {5'b11111, 20'h40032, 4'h0, 1'b1, 1'b0, 1'b0, 4'h3, 4'h3, 4'h4, 4'h9, 2'd2}, // R8 stay holdover
    {5'b11111, 20'h40032, 4'h0, 1'b1, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h9, 2'd1}, // R8 relock
    {5'b11111, 20'h11111, 4'h0, 1'b1, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h5, 2'd1}, // R1 ties
    {5'b11111, 20'h51234, 4'h0, 1'b1, 1'b0, 1'b1, 4'h6, 4'h6, 4'h5, 4'h4, 2'd1}, // R2 order
    {5'b11111, 20'h51234, 4'h5, 1'b1, 1'b0, 1'b1, 4'h5, 4'h6, 4'h5, 4'h4, 2'd1}, // R5 force
    {5'b01111, 20'h51234, 4'h9, 1'b1, 1'b0, 1'b1, 4'h0, 4'h6, 4'h5, 4'h4, 2'd2}, // R5 force invalid
    {5'b01111, 20'h51234, 4'h0, 1'b1, 1'b0, 1'b1, 4'h6, 4'h6, 4'h5, 4'h4, 2'd1}, // R5 release
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h9, 2'd1}, // R10 current disabled
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b1, 1'b1, 4'h4, 4'h4, 4'h3, 4'h9, 2'd1}, // R6 swap rise
    {5'b11111, 20'h40032, 4'h0, 1'b0, 1'b0, 1'b1, 4'h3, 4'h3, 4'h4, 4'h9, 2'd1}, // R6 swap fall
    {5'b11111, 20'h40030, 4'h0, 1'b1, 1'b0, 1'b1, 4'h4, 4'h4, 4'h9, 4'h0, 2'd1}  // R10 zero prio
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check("R8 reset sel",  {4'h0, sel_code},   8'h00);
    check("R8 reset mode", {6'h0, op_mode},    8'h00);
    check("R8 reset rank", {rank1_code, rank2_code}, 8'h00);
    check("R8 reset rank3", {4'h0, rank3_code}, 8'h00);
    check("R8 reset sync", {7'h0, sync_out},   8'h00);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      src_valid  = VEC[n][49:45];
      src_prio   = VEC[n][44:25];
      force_code = VEC[n][24:21];
      revertive  = VEC[n][20];
      swap_pin   = VEC[n][19];
      lock_ok    = VEC[n][18];
      settle();
      check($sformatf("R1 vec%0d sel", n), {4'h0, sel_code}, {4'h0, VEC[n][17:14]});
      check($sformatf("R2 vec%0d ranks12", n), {rank1_code, rank2_code}, VEC[n][13:6]);
      check($sformatf("R2 vec%0d rank3", n), {4'h0, rank3_code}, {4'h0, VEC[n][5:2]});
      check($sformatf("R7 vec%0d mode", n), {6'h0, op_mode}, {6'h0, VEC[n][1:0]});
    end

    // R9: Slave group selected (0100) -> sync_in[1]
    sync_in = 3'b010;
    settle();
    check("R9 slave sync high", {7'h0, sync_out}, 8'h01);
    sync_in = 3'b101;
    settle();
    check("R9 slave sync low", {7'h0, sync_out}, 8'h00);
    check("R9 sync ignored sel", {4'h0, sel_code}, 8'h04);
    sync_in = 3'b000;
    settle();
    check("R9 sync loss keeps sel", {4'h0, sel_code}, 8'h04);
    // R5 force stand-by, R9 stand-by sync
    force_code = 4'h9;
    sync_in = 3'b100;
    settle();
    check("R5 force standby", {4'h0, sel_code}, 8'h09);
    check("R9 standby sync", {7'h0, sync_out}, 8'h01);

    // R8 reset mid-run
    rst = 1'b1;
    settle();
    check("R8 rerst sel",  {4'h0, sel_code}, 8'h00);
    check("R8 rerst mode", {6'h0, op_mode},  8'h00);
    check("R8 rerst rank", {rank1_code, rank2_code}, 8'h00);
    check("R8 rerst sync", {7'h0, sync_out}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule